// File: doc/BRIEF.md
# 4x4 Inverse Transform and Reconstruction Unit

This block rebuilds one 4x4 tile of 8-bit pixels from sixteen signed 16-bit transform coefficients and sixteen unsigned 8-bit prediction samples. In full mode it runs a separable two-pass integer inverse transform. The transform uses two fixed-point rotation multipliers and saturating 16-bit arithmetic throughout. Each final value is rounded by an arithmetic shift of three, added to its prediction sample and clamped to the pixel range.

A single shared butterfly datapath does the work. A small sequencer steps it through four column operations and then four row operations. A DC-only mode skips the transform. It adds the rounded first coefficient to every prediction sample and finishes after a single cycle.

Coefficients and predictions are loaded in parallel on the cycle that `start` is accepted. The 16 results then appear together on `recon_out`, marked by a one-cycle `done` strobe. Element i of every flat bus is at bits [W*i+W-1 : W*i], where W is the element width (16 for coefficients, 8 for pixels). The index is raster order, i = 4*row + col.

Top module: `idct4x4_recon`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `done` is 0 and `recon_out` is all zeros.
- R2: The first pass works on column k (k = 0..3), that is, the coefficients at raster indices k, k+4, k+8 and k+12. Call them x0, x1, x2, x3.
  - Define m1(x) = x + ((x*20091) >> 16) and m2(x) = (x*35468) >> 16, with arithmetic shifts.
  - Compute a = x0+x2, b = x0-x2, c = m2(x1) - m1(x3) and d = m1(x1) + m2(x3).
  - The four results a+d, b+c, b-c and a-d go to row k of an intermediate array, at columns 0, 1, 2 and 3 in that order.
- R3: The second pass applies the same butterfly to column k of the intermediate array. Its four results become the pre-rounding values of output row k, at columns 0 to 3 in that order.
- R4: Every addition and subtraction in both passes saturates to the signed range -32768..32767, and so does the sum inside m1.
- R5: Each pre-rounding value v becomes (v+4) >> 3, using an arithmetic shift computed without overflow. That result is added to the zero-extended prediction sample at the same raster index, and the sum is clamped to 0..255.
- R6: When `dc_only` is 1 at an accepted start, every output pixel equals clamp(pred + ((coef0 + 4) >> 3)). Coefficients 1..15 have no effect.
- R7: `done` is high for exactly one cycle. It rises on the 9th rising edge after the edge that accepts a full-mode start, and on the 1st rising edge after the edge that accepts a DC-only start.
- R8: `recon_out` changes only on the edge that raises `done`, and it holds its value at all other times.
- R9: A `start` asserted while a tile is in progress is ignored. It produces no extra `done`, and it does not alter the result of the tile in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a tile when the block is idle |
| dc_only | input | 1 | Selects the DC-only path for this tile when 1 |
| coef_in | input | 256 | Sixteen signed 16-bit coefficients, raster order |
| pred_in | input | 128 | Sixteen unsigned 8-bit prediction samples, raster order |
| recon_out | output | 128 | Sixteen reconstructed 8-bit pixels, raster order |
| done | output | 1 | One-cycle strobe marking new `recon_out` |

## Verification
The checker tracks whether a tile is in flight from `start` and `done` alone. It therefore assumes that `start`, `dc_only` and `rst` are never unknown once reset has been released. It also assumes that `dc_only` only matters on the cycle a start is accepted, so the mode it latches there governs the latency it expects. The stimulus changes every input on the falling clock edge and raises `start` only for one cycle. Apart from one deliberate overlapping start, it waits for each tile's strobe before launching the next, so accepted starts and completions stay paired as the checker's model expects.

// File: rtl/idct_pkg.sv
package idct_pkg;
    localparam int COEF_W   = 16;
    localparam int PIX_W    = 8;
    localparam int N        = 4;
    localparam int NUM      = N * N;
    localparam int STEP_W   = $clog2(N);
    localparam int IDX_W    = $clog2(NUM);
    localparam int ROUND_SH = 3;
    localparam int FRAC_SH  = 16;
    localparam int PROD_W   = 2 * COEF_W + 1;
    localparam int LAT_FULL = 2 * N + 1;
    localparam int LAT_DC   = 1;
    localparam int PIX_MAX  = (1 << PIX_W) - 1;

    localparam logic signed [PROD_W-1:0] K_ROT_A = 20091;
    localparam logic signed [PROD_W-1:0] K_ROT_B = 35468;
    localparam logic signed [COEF_W:0]   S_MAX   = (1 << (COEF_W - 1)) - 1;
    localparam logic signed [COEF_W:0]   S_MIN   = -(1 << (COEF_W - 1));

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [PIX_W-1:0]         pix_t;
    typedef coef_t                    quad_t [N];

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_COLS,
        PH_ROWS,
        PH_EMIT
    } phase_t;

    function automatic logic signed [COEF_W:0] widen(input coef_t x);
        return (COEF_W + 1)'(x);
    endfunction

    function automatic coef_t sat16(input logic signed [COEF_W:0] v);
        if (v > S_MAX)      return coef_t'(S_MAX);
        else if (v < S_MIN) return coef_t'(S_MIN);
        else                return coef_t'(v);
    endfunction

    // x + x*20091/65536, the +1.0 term folded in, saturated
    function automatic coef_t rot_a(input coef_t x);
        logic signed [PROD_W-1:0] prod;
        logic signed [COEF_W:0]   frac;
        prod = PROD_W'(x) * K_ROT_A;
        frac = (COEF_W + 1)'(prod >>> FRAC_SH);
        return sat16(widen(x) + frac);
    endfunction

    // x*35468/65536, always within 16-bit range
    function automatic coef_t rot_b(input coef_t x);
        logic signed [PROD_W-1:0] prod;
        prod = PROD_W'(x) * K_ROT_B;
        return coef_t'(prod >>> FRAC_SH);
    endfunction
endpackage

// File: rtl/idct_butterfly.sv
module idct_butterfly
    import idct_pkg::*;
(
    input  quad_t q_in,
    output quad_t q_out
);
    coef_t sum_ev, dif_ev, odd_c, odd_d;

    always_comb begin
        sum_ev = sat16(widen(q_in[0]) + widen(q_in[2]));
        dif_ev = sat16(widen(q_in[0]) - widen(q_in[2]));
        odd_c  = sat16(widen(rot_b(q_in[1])) - widen(rot_a(q_in[3])));
        odd_d  = sat16(widen(rot_a(q_in[1])) + widen(rot_b(q_in[3])));
        q_out[0] = sat16(widen(sum_ev) + widen(odd_d));
        q_out[1] = sat16(widen(dif_ev) + widen(odd_c));
        q_out[2] = sat16(widen(dif_ev) - widen(odd_c));
        q_out[3] = sat16(widen(sum_ev) - widen(odd_d));
    end
endmodule

// File: rtl/idct_recon_pix.sv
module idct_recon_pix
    import idct_pkg::*;
(
    input  coef_t v,
    input  pix_t  pred,
    output pix_t  px
);
    localparam logic signed [COEF_W:0] RND_BIAS = 1 << (ROUND_SH - 1);

    logic signed [COEF_W:0]   biased;
    logic signed [COEF_W:0]   rnd;
    logic signed [COEF_W+1:0] pext;
    logic signed [COEF_W+1:0] sum;

    always_comb begin
        biased = widen(v) + RND_BIAS;
        rnd    = biased >>> ROUND_SH;
        pext   = {{(COEF_W + 2 - PIX_W){1'b0}}, pred};
        sum    = (COEF_W + 2)'(rnd) + pext;
        if (sum < 0)
            px = '0;
        else if (sum > PIX_MAX)
            px = pix_t'(PIX_MAX);
        else
            px = sum[PIX_W-1:0];
    end
endmodule

// File: rtl/idct_seq.sv
module idct_seq
    import idct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dc_only,
    output phase_t            phase,
    output logic [STEP_W-1:0] step,
    output logic              capture
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(N - 1);

    assign capture = (phase == PH_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    step <= '0;
                    if (start) phase <= dc_only ? PH_EMIT : PH_COLS;
                end
                PH_COLS: begin
                    step <= step + 1'b1;
                    if (step == LAST) phase <= PH_ROWS;
                end
                PH_ROWS: begin
                    step <= step + 1'b1;
                    if (step == LAST) phase <= PH_EMIT;
                end
                PH_EMIT: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/idct4x4_recon.sv
module idct4x4_recon
    import idct_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  dc_only,
    input  logic [NUM*COEF_W-1:0] coef_in,
    input  logic [NUM*PIX_W-1:0]  pred_in,
    output logic [NUM*PIX_W-1:0]  recon_out,
    output logic                  done
);
    phase_t            phase;
    logic [STEP_W-1:0] step;
    logic              capture;

    coef_t src_q [NUM];   // input coefficients, later second-pass results
    coef_t mid_q [NUM];   // first-pass results, row k holds column k
    pix_t  pred_q[NUM];
    pix_t  px_w  [NUM];
    quad_t bf_in, bf_out;

    idct_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .dc_only (dc_only),
        .phase   (phase),
        .step    (step),
        .capture (capture)
    );

    always_comb begin
        for (int j = 0; j < N; j++) begin
            logic [IDX_W-1:0] rd;
            rd = {STEP_W'(j), step};
            bf_in[j] = (phase == PH_ROWS) ? mid_q[rd] : src_q[rd];
        end
    end

    idct_butterfly u_bfly (
        .q_in  (bf_in),
        .q_out (bf_out)
    );

    for (genvar g = 0; g < NUM; g++) begin : g_pix
        idct_recon_pix u_px (
            .v    (src_q[g]),
            .pred (pred_q[g]),
            .px   (px_w[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM; i++) begin
                src_q[i]  <= '0;
                mid_q[i]  <= '0;
                pred_q[i] <= '0;
            end
            recon_out <= '0;
            done      <= 1'b0;
        end else begin
            done <= (phase == PH_EMIT);
            if (capture) begin
                for (int i = 0; i < NUM; i++) begin
                    src_q[i]  <= dc_only ? coef_t'(coef_in[COEF_W-1:0])
                                         : coef_t'(coef_in[i*COEF_W +: COEF_W]);
                    pred_q[i] <= pred_in[i*PIX_W +: PIX_W];
                end
            end
            if (phase == PH_COLS) begin
                for (int j = 0; j < N; j++)
                    mid_q[{step, STEP_W'(j)}] <= bf_out[j];
            end
            if (phase == PH_ROWS) begin
                for (int j = 0; j < N; j++)
                    src_q[{step, STEP_W'(j)}] <= bf_out[j];
            end
            if (phase == PH_EMIT) begin
                for (int i = 0; i < NUM; i++)
                    recon_out[i*PIX_W +: PIX_W] <= px_w[i];
            end
        end
    end
endmodule

// File: rtl/idct4x4_recon_chk.sv
module idct4x4_recon_chk
    import idct_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 dc_only,
    input logic                 done,
    input logic [NUM*PIX_W-1:0] recon_out
);
    logic       busy_m;
    logic       dc_m;
    logic [7:0] cnt_m;
    logic       accept_m;

    assign accept_m = start && (!busy_m || done);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_m <= 1'b0;
            dc_m   <= 1'b0;
            cnt_m  <= '0;
        end else if (accept_m) begin
            busy_m <= 1'b1;
            dc_m   <= dc_only;
            cnt_m  <= '0;
        end else begin
            if (done) busy_m <= 1'b0;
            if (busy_m && cnt_m != 8'hFF) cnt_m <= cnt_m + 1'b1;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R7
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_m == 8'(dc_m ? LAT_DC : LAT_FULL)));                 // R7
    AST_DC_FAST: assert property (@(posedge clk) disable iff (rst)
        (accept_m && dc_only) |-> ##2 done);                               // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(recon_out));                                     // R8
    AST_DONE_NEEDS_TILE: assert property (@(posedge clk) disable iff (rst)
        done |-> busy_m);                                                  // R9
endmodule

bind idct4x4_recon idct4x4_recon_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dc_only   (dc_only),
    .done      (done),
    .recon_out (recon_out)
);

// File: tb/tb_idct4x4_recon.sv
module tb_idct4x4_recon;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         dc_only = 1'b0;
    logic [255:0] coef_in = '0;
    logic [127:0] pred_in = '0;
    logic [127:0] recon_out;
    logic         done;

    always #4 clk = ~clk;  // 125 MHz

    idct4x4_recon dut (
        .clk(clk), .rst(rst), .start(start), .dc_only(dc_only),
        .coef_in(coef_in), .pred_in(pred_in),
        .recon_out(recon_out), .done(done)
    );

    typedef struct {
        logic [127:0] exp;
        int           lat;
        int           stamp;
        string        tag;
    } item_t;

    item_t        sb[$];
    int           n_checks = 0;
    int           n_fails  = 0;
    int           cyc      = 0;
    int           stray    = 0;
    logic [127:0] last_exp = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic int s16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction
    function automatic int mul_a(input int x);
        return s16(x + ((x * 20091) >>> 16));
    endfunction
    function automatic int mul_b(input int x);
        return (x * 35468) >>> 16;
    endfunction
    function automatic int pixclip(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic logic [127:0] model(input int c[16], input int p[16], input bit dc);
        int t[16];
        int r[16];
        logic [127:0] o;
        if (dc) begin
            for (int i = 0; i < 16; i++) r[i] = c[0];
        end else begin
            for (int pass = 0; pass < 2; pass++) begin
                for (int k = 0; k < 4; k++) begin
                    int x0, x1, x2, x3, ea, eb, oc, od;
                    x0 = (pass == 0) ? c[k]      : t[k];
                    x1 = (pass == 0) ? c[k + 4]  : t[k + 4];
                    x2 = (pass == 0) ? c[k + 8]  : t[k + 8];
                    x3 = (pass == 0) ? c[k + 12] : t[k + 12];
                    ea = s16(x0 + x2);
                    eb = s16(x0 - x2);
                    oc = s16(mul_b(x1) - mul_a(x3));
                    od = s16(mul_a(x1) + mul_b(x3));
                    if (pass == 0) begin
                        t[4*k]   = s16(ea + od); t[4*k+1] = s16(eb + oc);
                        t[4*k+2] = s16(eb - oc); t[4*k+3] = s16(ea - od);
                    end else begin
                        r[4*k]   = s16(ea + od); r[4*k+1] = s16(eb + oc);
                        r[4*k+2] = s16(eb - oc); r[4*k+3] = s16(ea - od);
                    end
                end
            end
        end
        for (int i = 0; i < 16; i++)
            o[8*i +: 8] = 8'(pixclip(((r[i] + 4) >>> 3) + p[i]));
        return o;
    endfunction

    // ---------------- driver ----------------
    task automatic launch(input int c[16], input int p[16], input bit dc, input string tag);
        item_t it;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            coef_in[16*i +: 16] = 16'(c[i]);
            pred_in[8*i +: 8]   = 8'(p[i]);
        end
        dc_only = dc;
        start   = 1'b1;
        it.exp   = model(c, p, dc);
        it.lat   = dc ? 1 : 9;
        it.stamp = cyc;
        it.tag   = tag;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0;
        wait (sb.size() == 0);
    endtask

    // ---------------- monitor ----------------
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                if (sb.size() == 0) begin
                    stray++;
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(recon_out === it.exp, it.tag, recon_out, it.exp);
                    check((cyc - it.stamp - 1) == it.lat, "R7 latency",
                          128'(cyc - it.stamp - 1), 128'(it.lat));
                    last_exp = it.exp;
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int c[16];
        int p[16];
        void'($urandom(7));
        repeat (3) @(negedge clk);
        check(done === 1'b0 && recon_out === '0, "R1 in reset", recon_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && recon_out === '0, "R1 after reset", recon_out, '0);

        // R5: zero residual reproduces prediction
        for (int i = 0; i < 16; i++) begin c[i] = 0; p[i] = 16 * i + 3; end
        launch(c, p, 1'b0, "R5 zero residual");

        // R2/R3: single coefficients probe ordering of both passes
        for (int i = 0; i < 16; i++) p[i] = 128;
        for (int pos = 0; pos < 16; pos += 5) begin
            for (int i = 0; i < 16; i++) c[i] = 0;
            c[pos] = 400 - 60 * pos;
            launch(c, p, 1'b0, "R2 R3 single coefficient");
        end

        // R2/R3/R5: random small coefficients
        for (int n = 0; n < 20; n++) begin
            for (int i = 0; i < 16; i++) begin
                c[i] = int'($urandom_range(600)) - 300;
                p[i] = int'($urandom_range(255));
            end
            launch(c, p, 1'b0, "R2 R3 R5 random");
        end

        // R4: full-range coefficients drive saturation
        for (int n = 0; n < 10; n++) begin
            for (int i = 0; i < 16; i++) begin
                c[i] = int'($urandom_range(65535)) - 32768;
                p[i] = int'($urandom_range(255));
            end
            launch(c, p, 1'b0, "R4 full range");
        end
        for (int i = 0; i < 16; i++) begin c[i] = 32767; p[i] = 0; end
        launch(c, p, 1'b0, "R4 all max");
        for (int i = 0; i < 16; i++) begin c[i] = -32768; p[i] = 255; end
        launch(c, p, 1'b0, "R4 all min");

        // R6: DC-only mode, clamp high and low, other coefficients ignored
        for (int i = 0; i < 16; i++) begin c[i] = 0; p[i] = 240 + i; end
        c[0] = 100;
        launch(c, p, 1'b1, "R6 dc clamp high");
        for (int i = 0; i < 16; i++) p[i] = 10 * i;
        c[0] = -2000;
        launch(c, p, 1'b1, "R6 dc clamp low");
        for (int i = 1; i < 16; i++) c[i] = int'($urandom_range(60000)) - 30000;
        c[0] = 37;
        launch(c, p, 1'b1, "R6 dc ignores others");

        // R8: output holds after the strobe
        repeat (6) @(negedge clk);
        check(recon_out === last_exp, "R8 hold", recon_out, last_exp);

        // R9: a second start during a tile is ignored
        for (int i = 0; i < 16; i++) begin
            c[i] = int'($urandom_range(800)) - 400;
            p[i] = int'($urandom_range(255));
        end
        fork
            launch(c, p, 1'b0, "R9 busy start");
            begin
                int c2[16];
                int p2[16];
                repeat (3) @(negedge clk);
                for (int i = 0; i < 16; i++) begin
                    coef_in[16*i +: 16] = 16'(1000 + i);
                    pred_in[8*i +: 8]   = 8'(7 * i);
                end
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                c2[0] = 0; p2[0] = 0;
            end
        join
        repeat (14) @(negedge clk);
        check(stray == 0, "R9 no extra done", 128'(stray), 128'(0));
        check(recon_out === last_exp, "R8 R9 output unchanged", recon_out, last_exp);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule